// File: doc/BRIEF.md
# Two-Stage Circle Centre Voter

This block locates the centre of a circle whose radius is known, given the edge points of a binary image. Each edge point arrives as one beat carrying its column and row. Every point is swept around a 32-point circle of the requested radius, and each resulting candidate centre that lands inside the image casts a vote.

The frame is presented twice. On the first presentation the votes go into a grid of tiles, where one cell stands for a whole block of pixels. The winning tile is then found by a scan. On the second presentation only candidates inside that tile vote, into two one-dimensional tallies: one indexed by column and one by row. The column with the highest tally and the row with the highest tally form the reported centre.

Total vote storage is roughly the pixel count divided by the tile area, plus one row and one column of counters. A one-cycle completion pulse carries the centre and the winning tile's vote count.

Top module: `chc_top`

## Requirements
- R1: While reset is held, and on leaving it, `done` is low, `in_ready` is high and `ctr_x`, `ctr_y` and `peak_cnt` are zero.
- R2: Point k (0..31) of the offset circle uses quadrant q = k/8 and step j = k%8. The base values are c = round(r*C[j]/128) and s = round(r*C[8-j]/128), where C = 128,126,118,106,91,71,49,25 for j = 0..7, C[8] = 0, and rounding is floor((r*v+64)/128). The offset (dx,dy) is (c,s), (-s,c), (-c,-s) or (s,-c) for q = 0, 1, 2 and 3.
- R3: An edge point (x,y) proposes the candidate centre (x-dx, y-dy) for each of the 32 offsets. A candidate is discarded unless 0 <= x-dx < IMG_W and 0 <= y-dy < IMG_H.
- R4: In the first pass each kept candidate increments the grid cell (cand_x / TILE_W, cand_y / TILE_H).
- R5: After the first pass the winning cell is the one with the largest count. Ties go to the lowest row-major index cy*(IMG_W/TILE_W)+cx. An all-zero grid yields cell (0,0) with count 0.
- R6: In the second pass a kept candidate votes only when it falls inside the winning cell. It then increments the column tally at cand_x and the row tally at cand_y, each independently of the other.
- R7: `ctr_x` is the column with the largest column tally and `ctr_y` is the row with the largest row tally. Ties go to the lowest index.
- R8: Every counter saturates at 2^CNT_W-1 and does not wrap.
- R9: A beat with `in_sof` set clears the accumulators of the pass it belongs to. The result of a frame therefore does not depend on earlier frames.
- R10: A beat is accepted when `in_valid` and `in_ready` are both high. An accepted edge beat (`in_edge`=1) holds `in_ready` low for exactly 32 cycles. A beat with `in_edge`=0 casts no votes and takes one cycle. An empty pass is sent as one beat with `in_edge`=0, `in_sof`=1 and `in_eof`=1.
- R11: After the second pass ends, `done` pulses high for exactly one cycle. `ctr_x`, `ctr_y` and `peak_cnt` (the winning cell count) change only in that cycle and hold afterwards.
- R12: The beat carrying `in_eof` ends a pass. `in_ready` then stays low until the peak scan of that pass is complete, so second-pass beats are taken only after the winning cell is fixed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat offered |
| in_ready | output | 1 | Block can take a beat |
| in_x | input | X_W | Column of the edge point |
| in_y | input | Y_W | Row of the edge point |
| in_edge | input | 1 | Beat is a real edge point (0 = placeholder) |
| in_sof | input | 1 | First beat of a pass |
| in_eof | input | 1 | Last beat of a pass |
| radius | input | R_W | Circle radius in pixels |
| done | output | 1 | One-cycle result pulse |
| ctr_x | output | X_W | Detected centre column |
| ctr_y | output | Y_W | Detected centre row |
| peak_cnt | output | CNT_W | Vote count of the winning tile |

## Verification
The bench runs several stimulus patterns on a small 32x24 image with 4x4 tiles and compares every result with a behavioural model computed from the offset formula.

- A complete circle drives the grid peak and the tallies into saturation, which separates saturating counters from wrapping ones.
- Half an arc with scattered noise points spreads the votes out, so the tie order and the tile gating both affect the outcome.
- A circle clipped by the image border, with a small radius, exercises discarded candidates and duplicate offsets.
- An empty frame shows the all-zero defaults.
- A frame repeated after unrelated frames shows that each pass starts from cleared storage.

// File: rtl/chc_pkg.sv
package chc_pkg;

  localparam int PTS_PER_QUAD = 8;
  localparam int NUM_PTS      = 4 * PTS_PER_QUAD;
  localparam int PT_W         = $clog2(NUM_PTS);

  typedef enum logic [2:0] {
    ST_WAIT0 = 3'd0,
    ST_VOTE0 = 3'd1,
    ST_SCAN0 = 3'd2,
    ST_WAIT1 = 3'd3,
    ST_VOTE1 = 3'd4,
    ST_SCAN1 = 3'd5
  } chc_state_e;

  function automatic int clog_min1(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // cos of j*11.25 degrees scaled by 128
  function automatic logic [7:0] unit_cos(input logic [2:0] j);
    case (j)
      3'd0: return 8'd128;
      3'd1: return 8'd126;
      3'd2: return 8'd118;
      3'd3: return 8'd106;
      3'd4: return 8'd91;
      3'd5: return 8'd71;
      3'd6: return 8'd49;
      default: return 8'd25;
    endcase
  endfunction

  function automatic logic [7:0] unit_sin(input logic [2:0] j);
    if (j == 3'd0) return 8'd0;
    return unit_cos(3'(4'd8 - {1'b0, j}));
  endfunction

endpackage

// File: rtl/chc_offset_gen.sv
module chc_offset_gen
  import chc_pkg::*;
#(
  parameter  int R_W = 8,
  localparam int D_W = R_W + 2
) (
  input  logic [R_W-1:0]        radius,
  input  logic [PT_W-1:0]       pt,
  output logic signed [D_W-1:0] dx,
  output logic signed [D_W-1:0] dy
);

  localparam int P_W = R_W + 7;

  logic [7:0]            cv, sv;
  logic [P_W-1:0]        pc, ps;
  logic [R_W-1:0]        cm, sm;
  logic signed [D_W-1:0] cpos, spos;
  logic [1:0]            quad;

  always_comb begin
    quad = pt[PT_W-1 -: 2];
    cv   = unit_cos(pt[2:0]);
    sv   = unit_sin(pt[2:0]);
    pc   = P_W'(radius) * P_W'(cv) + P_W'(64);
    ps   = P_W'(radius) * P_W'(sv) + P_W'(64);
    cm   = R_W'(pc >> 7);
    sm   = R_W'(ps >> 7);
    cpos = signed'({2'b00, cm});
    spos = signed'({2'b00, sm});
    case (quad)
      2'd0:    begin dx = cpos;  dy = spos;  end
      2'd1:    begin dx = -spos; dy = cpos;  end
      2'd2:    begin dx = -cpos; dy = -spos; end
      default: begin dx = spos;  dy = -cpos; end
    endcase
  end

endmodule

// File: rtl/chc_coarse_acc.sv
module chc_coarse_acc
  import chc_pkg::*;
#(
  parameter  int GW    = 40,
  parameter  int GH    = 30,
  parameter  int CNT_W = 8,
  localparam int GX_W  = clog_min1(GW),
  localparam int GY_W  = clog_min1(GH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             vote,
  input  logic [GX_W-1:0]  vote_cx,
  input  logic [GY_W-1:0]  vote_cy,
  input  logic             scan_start,
  output logic             scan_busy,
  output logic [GX_W-1:0]  peak_cx,
  output logic [GY_W-1:0]  peak_cy,
  output logic [CNT_W-1:0] peak_cnt
);

  localparam logic [CNT_W-1:0] CAP = '1;

  logic [CNT_W-1:0] cell_q [GH][GW];
  logic [CNT_W-1:0] bump;

  logic             busy_q, busy_n;
  logic [GX_W-1:0]  sx_q, sx_n, bx_q, bx_n;
  logic [GY_W-1:0]  sy_q, sy_n, by_q, by_n;
  logic [CNT_W-1:0] bc_q, bc_n, cur;

  always_comb begin
    bump = (cell_q[vote_cy][vote_cx] == CAP) ? CAP : cell_q[vote_cy][vote_cx] + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < GH; r++)
        for (int c = 0; c < GW; c++)
          cell_q[r][c] <= '0;
    end else if (clr) begin
      for (int r = 0; r < GH; r++)
        for (int c = 0; c < GW; c++)
          cell_q[r][c] <= '0;
    end else if (vote) begin
      cell_q[vote_cy][vote_cx] <= bump;
    end
  end

  // row-major scan, strict compare keeps the lowest index on ties
  always_comb begin
    busy_n = busy_q;
    sx_n   = sx_q;
    sy_n   = sy_q;
    bx_n   = bx_q;
    by_n   = by_q;
    bc_n   = bc_q;
    cur    = cell_q[sy_q][sx_q];
    if (scan_start) begin
      busy_n = 1'b1;
      sx_n   = '0;
      sy_n   = '0;
      bx_n   = '0;
      by_n   = '0;
      bc_n   = '0;
    end else if (busy_q) begin
      if (cur > bc_q) begin
        bc_n = cur;
        bx_n = sx_q;
        by_n = sy_q;
      end
      if (sx_q == GX_W'(GW - 1)) begin
        sx_n = '0;
        if (sy_q == GY_W'(GH - 1)) busy_n = 1'b0;
        else                       sy_n   = sy_q + 1'b1;
      end else begin
        sx_n = sx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sx_q   <= '0;
      sy_q   <= '0;
      bx_q   <= '0;
      by_q   <= '0;
      bc_q   <= '0;
    end else begin
      busy_q <= busy_n;
      sx_q   <= sx_n;
      sy_q   <= sy_n;
      bx_q   <= bx_n;
      by_q   <= by_n;
      bc_q   <= bc_n;
    end
  end

  assign scan_busy = busy_q;
  assign peak_cx   = bx_q;
  assign peak_cy   = by_q;
  assign peak_cnt  = bc_q;

endmodule

// File: rtl/chc_line_acc.sv
module chc_line_acc
  import chc_pkg::*;
#(
  parameter  int N     = 320,
  parameter  int CNT_W = 8,
  localparam int I_W   = clog_min1(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             vote,
  input  logic [I_W-1:0]   vote_idx,
  input  logic             scan_start,
  output logic             scan_busy,
  output logic [I_W-1:0]   peak_idx
);

  localparam logic [CNT_W-1:0] CAP = '1;

  logic [CNT_W-1:0] cnt_q [N];
  logic [CNT_W-1:0] bump, cur;

  logic             busy_q, busy_n;
  logic [I_W-1:0]   idx_q, idx_n, bi_q, bi_n;
  logic [CNT_W-1:0] bc_q, bc_n;

  always_comb begin
    bump = (cnt_q[vote_idx] == CAP) ? CAP : cnt_q[vote_idx] + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) cnt_q[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < N; i++) cnt_q[i] <= '0;
    end else if (vote) begin
      cnt_q[vote_idx] <= bump;
    end
  end

  always_comb begin
    busy_n = busy_q;
    idx_n  = idx_q;
    bi_n   = bi_q;
    bc_n   = bc_q;
    cur    = cnt_q[idx_q];
    if (scan_start) begin
      busy_n = 1'b1;
      idx_n  = '0;
      bi_n   = '0;
      bc_n   = '0;
    end else if (busy_q) begin
      if (cur > bc_q) begin
        bc_n = cur;
        bi_n = idx_q;
      end
      if (idx_q == I_W'(N - 1)) busy_n = 1'b0;
      else                      idx_n  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      bi_q   <= '0;
      bc_q   <= '0;
    end else begin
      busy_q <= busy_n;
      idx_q  <= idx_n;
      bi_q   <= bi_n;
      bc_q   <= bc_n;
    end
  end

  assign scan_busy = busy_q;
  assign peak_idx  = bi_q;

endmodule

// File: rtl/chc_top.sv
module chc_top
  import chc_pkg::*;
#(
  parameter  int IMG_W  = 320,
  parameter  int IMG_H  = 240,
  parameter  int TILE_W = 8,
  parameter  int TILE_H = 8,
  parameter  int R_W    = 8,
  parameter  int CNT_W  = 8,
  localparam int X_W    = clog_min1(IMG_W),
  localparam int Y_W    = clog_min1(IMG_H)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [X_W-1:0]   in_x,
  input  logic [Y_W-1:0]   in_y,
  input  logic             in_edge,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [R_W-1:0]   radius,
  output logic             done,
  output logic [X_W-1:0]   ctr_x,
  output logic [Y_W-1:0]   ctr_y,
  output logic [CNT_W-1:0] peak_cnt
);

  localparam int GW   = IMG_W / TILE_W;
  localparam int GH   = IMG_H / TILE_H;
  localparam int GX_W = clog_min1(GW);
  localparam int GY_W = clog_min1(GH);
  localparam int D_W  = R_W + 2;
  localparam int XY_W = (X_W > Y_W) ? X_W : Y_W;
  localparam int CW   = ((XY_W > R_W) ? XY_W : R_W) + 2;

  chc_state_e st_q, st_n;
  logic [PT_W-1:0] pt_q, pt_n;
  logic [X_W-1:0]  px_q;
  logic [Y_W-1:0]  py_q;
  logic [R_W-1:0]  rad_q;
  logic            eof_q;
  logic            accept, last_pt;

  logic signed [D_W-1:0] dx, dy;
  logic signed [CW-1:0]  cand_x, cand_y;
  logic [X_W-1:0]        cand_xu;
  logic [Y_W-1:0]        cand_yu;
  logic [GX_W-1:0]       tile_x, win_cx;
  logic [GY_W-1:0]       tile_y, win_cy;
  logic [CNT_W-1:0]      win_cnt;
  logic                  in_img, in_win;
  logic                  coarse_vote, fine_vote, coarse_clr, fine_clr;
  logic                  coarse_start, fine_start;
  logic                  coarse_busy, col_busy, row_busy;
  logic [X_W-1:0]        best_col;
  logic [Y_W-1:0]        best_row;
  logic                  done_n;

  assign in_ready = (st_q == ST_WAIT0) || (st_q == ST_WAIT1);
  assign accept   = in_valid && in_ready;
  assign last_pt  = (pt_q == PT_W'(NUM_PTS - 1));

  chc_offset_gen #(.R_W(R_W)) u_off (
    .radius (rad_q),
    .pt     (pt_q),
    .dx     (dx),
    .dy     (dy)
  );

  always_comb begin
    cand_x  = CW'(signed'({1'b0, px_q})) - CW'(dx);
    cand_y  = CW'(signed'({1'b0, py_q})) - CW'(dy);
    in_img  = (cand_x >= 0) && (cand_x < CW'(IMG_W)) &&
              (cand_y >= 0) && (cand_y < CW'(IMG_H));
    cand_xu = cand_x[X_W-1:0];
    cand_yu = cand_y[Y_W-1:0];
    tile_x  = GX_W'(32'(cand_xu) / TILE_W);
    tile_y  = GY_W'(32'(cand_yu) / TILE_H);
    in_win  = (tile_x == win_cx) && (tile_y == win_cy);
  end

  assign coarse_vote = (st_q == ST_VOTE0) && in_img;
  assign fine_vote   = (st_q == ST_VOTE1) && in_img && in_win;
  assign coarse_clr  = accept && in_sof && (st_q == ST_WAIT0);
  assign fine_clr    = accept && in_sof && (st_q == ST_WAIT1);

  // sequencing of the two passes
  always_comb begin
    st_n = st_q;
    pt_n = pt_q;
    case (st_q)
      ST_WAIT0, ST_WAIT1: begin
        if (accept) begin
          pt_n = '0;
          if (in_edge)     st_n = (st_q == ST_WAIT0) ? ST_VOTE0 : ST_VOTE1;
          else if (in_eof) st_n = (st_q == ST_WAIT0) ? ST_SCAN0 : ST_SCAN1;
        end
      end
      ST_VOTE0, ST_VOTE1: begin
        pt_n = pt_q + 1'b1;
        if (last_pt) begin
          if (st_q == ST_VOTE0) st_n = eof_q ? ST_SCAN0 : ST_WAIT0;
          else                  st_n = eof_q ? ST_SCAN1 : ST_WAIT1;
        end
      end
      ST_SCAN0: if (!coarse_busy) st_n = ST_WAIT1;
      ST_SCAN1: if (!col_busy && !row_busy) st_n = ST_WAIT0;
      default:  st_n = ST_WAIT0;
    endcase
  end

  assign coarse_start = (st_q != ST_SCAN0) && (st_n == ST_SCAN0);
  assign fine_start   = (st_q != ST_SCAN1) && (st_n == ST_SCAN1);
  assign done_n       = (st_q == ST_SCAN1) && !col_busy && !row_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_WAIT0;
      pt_q <= '0;
    end else begin
      st_q <= st_n;
      pt_q <= pt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px_q  <= '0;
      py_q  <= '0;
      rad_q <= '0;
      eof_q <= 1'b0;
    end else if (accept) begin
      px_q  <= in_x;
      py_q  <= in_y;
      rad_q <= radius;
      eof_q <= in_eof;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      ctr_x    <= '0;
      ctr_y    <= '0;
      peak_cnt <= '0;
    end else begin
      done <= done_n;
      if (done_n) begin
        ctr_x    <= best_col;
        ctr_y    <= best_row;
        peak_cnt <= win_cnt;
      end
    end
  end

  chc_coarse_acc #(.GW(GW), .GH(GH), .CNT_W(CNT_W)) u_coarse (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (coarse_clr),
    .vote       (coarse_vote),
    .vote_cx    (tile_x),
    .vote_cy    (tile_y),
    .scan_start (coarse_start),
    .scan_busy  (coarse_busy),
    .peak_cx    (win_cx),
    .peak_cy    (win_cy),
    .peak_cnt   (win_cnt)
  );

  chc_line_acc #(.N(IMG_W), .CNT_W(CNT_W)) u_cols (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (fine_clr),
    .vote       (fine_vote),
    .vote_idx   (cand_xu),
    .scan_start (fine_start),
    .scan_busy  (col_busy),
    .peak_idx   (best_col)
  );

  chc_line_acc #(.N(IMG_H), .CNT_W(CNT_W)) u_rows (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (fine_clr),
    .vote       (fine_vote),
    .vote_idx   (cand_yu),
    .scan_start (fine_start),
    .scan_busy  (row_busy),
    .peak_idx   (best_row)
  );

endmodule

// File: rtl/chc_checker.sv
module chc_checker #(
  parameter int X_W   = 9,
  parameter int Y_W   = 8,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_edge,
  input logic             in_eof,
  input logic             done,
  input logic [X_W-1:0]   ctr_x,
  input logic [Y_W-1:0]   ctr_y,
  input logic [CNT_W-1:0] peak_cnt,
  input logic             coarse_vote,
  input logic             fine_vote
);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ctr_x) || !$stable(ctr_y) || !$stable(peak_cnt)) |-> done);

  p_ready_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_edge) |=> !in_ready);

  p_eof_scan_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_edge && in_eof) |=> !in_ready);

  p_vote_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (coarse_vote || fine_vote) |-> !in_ready);

  p_one_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(coarse_vote && fine_vote));

endmodule

bind chc_top chc_checker #(.X_W(X_W), .Y_W(Y_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_edge     (in_edge),
  .in_eof      (in_eof),
  .done        (done),
  .ctr_x       (ctr_x),
  .ctr_y       (ctr_y),
  .peak_cnt    (peak_cnt),
  .coarse_vote (coarse_vote),
  .fine_vote   (fine_vote)
);

// File: tb/sim_chc_top.sv
`timescale 1ns/1ps
module sim_chc_top;

  localparam int IW = 32, IH = 24, TW = 4, TH = 4, RW = 5, CW = 5;
  localparam int GW = IW / TW, GH = IH / TH;
  localparam int CAP = (1 << CW) - 1;
  localparam int KP = 32;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_edge = 0, in_sof = 0, in_eof = 0;
  logic [4:0] in_x = 0, in_y = 0;
  logic [RW-1:0] radius = 0;
  logic in_ready, done;
  logic [4:0] ctr_x, ctr_y;
  logic [CW-1:0] peak_cnt;

  always #2 clk = ~clk;

  chc_top #(.IMG_W(IW), .IMG_H(IH), .TILE_W(TW), .TILE_H(TH), .R_W(RW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_edge(in_edge), .in_sof(in_sof), .in_eof(in_eof),
    .radius(radius), .done(done), .ctr_x(ctr_x), .ctr_y(ctr_y), .peak_cnt(peak_cnt));

  int n_chk = 0, n_bad = 0;
  int fx[256], fy[256];
  int fn;
  int ex, ey, ep;
  int gx, gy, gp;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    finish_up();
  end

  // R2 offset formula
  function automatic int ucos(int j);
    int t[9] = '{128, 126, 118, 106, 91, 71, 49, 25, 0};
    return t[j];
  endfunction

  function automatic void offs(int k, int r, output int dx, output int dy);
    int q = k / 8, j = k % 8;
    int c = (r * ucos(j) + 64) / 128;
    int s = (r * ucos(8 - j) + 64) / 128;
    case (q)
      0: begin dx = c;  dy = s;  end
      1: begin dx = -s; dy = c;  end
      2: begin dx = -c; dy = -s; end
      default: begin dx = s; dy = -c; end
    endcase
  endfunction

  function automatic int sat(int v);
    return (v >= CAP) ? CAP : v + 1;
  endfunction

  task automatic model(int r);
    int co[GW*GH];
    int cc[IW];
    int rc[IH];
    int best, wi, wcx, wcy, dx, dy, a, b;
    foreach (co[i]) co[i] = 0;
    foreach (cc[i]) cc[i] = 0;
    foreach (rc[i]) rc[i] = 0;
    for (int i = 0; i < fn; i++)
      for (int k = 0; k < KP; k++) begin
        offs(k, r, dx, dy);
        a = fx[i] - dx; b = fy[i] - dy;
        if (a >= 0 && a < IW && b >= 0 && b < IH)
          co[(b / TH) * GW + a / TW] = sat(co[(b / TH) * GW + a / TW]);
      end
    best = 0; wi = 0;
    for (int i = 0; i < GW*GH; i++) if (co[i] > best) begin best = co[i]; wi = i; end
    wcx = wi % GW; wcy = wi / GW; ep = best;
    for (int i = 0; i < fn; i++)
      for (int k = 0; k < KP; k++) begin
        offs(k, r, dx, dy);
        a = fx[i] - dx; b = fy[i] - dy;
        if (a >= 0 && a < IW && b >= 0 && b < IH && a / TW == wcx && b / TH == wcy) begin
          cc[a] = sat(cc[a]);
          rc[b] = sat(rc[b]);
        end
      end
    best = 0; ex = 0;
    for (int i = 0; i < IW; i++) if (cc[i] > best) begin best = cc[i]; ex = i; end
    best = 0; ey = 0;
    for (int i = 0; i < IH; i++) if (rc[i] > best) begin best = rc[i]; ey = i; end
  endtask

  task automatic add_arc(int cx, int cy, int r, int k0, int k1);
    int dx, dy, x, y;
    for (int k = k0; k <= k1; k++) begin
      offs(k, r, dx, dy);
      x = cx + dx; y = cy + dy;
      if (x >= 0 && x < IW && y >= 0 && y < IH) begin
        fx[fn] = x; fy[fn] = y; fn++;
      end
    end
  endtask

  task automatic add_pt(int x, int y);
    fx[fn] = x; fy[fn] = y; fn++;
  endtask

  task automatic send_beat(int x, int y, bit e, bit s, bit f);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_x = 5'(x); in_y = 5'(y); in_edge = e; in_sof = s; in_eof = f;
    @(posedge clk);
    #1 in_valid = 0; in_sof = 0; in_eof = 0;
  endtask

  task automatic run_frame(string nm, int r, bit chk_ready);
    int lowc;
    radius = RW'(r);
    model(r);
    for (int p = 0; p < 2; p++) begin
      if (fn == 0) send_beat(0, 0, 0, 1, 1);
      else
        for (int i = 0; i < fn; i++) begin
          send_beat(fx[i], fy[i], 1, i == 0, i == fn - 1);
          if (chk_ready && p == 0 && i == 0) begin
            lowc = 0;
            @(negedge clk);
            while (!in_ready) begin lowc++; @(negedge clk); end
            check({nm, " R10 ready low cycles"}, lowc, KP);
          end
        end
    end
    @(negedge clk);
    while (!done) @(negedge clk);
    gx = ctr_x; gy = ctr_y; gp = peak_cnt;
    check({nm, " R7 ctr_x"}, gx, ex);
    check({nm, " R7 ctr_y"}, gy, ey);
    check({nm, " R5 peak_cnt"}, gp, ep);
    @(negedge clk);
    check({nm, " R11 done one cycle"}, done, 0);
    check({nm, " R11 ctr_x held"}, ctr_x, gx);
  endtask

  int f2x, f2y, f2p;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 in_ready in reset", in_ready, 1);
    check("R1 done in reset", done, 0);
    check("R1 outputs in reset", ctr_x + ctr_y + peak_cnt, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 in_ready after reset", in_ready, 1);

    // full circle, saturation R8, R4, R6
    fn = 0; add_arc(16, 12, 6, 0, 31);
    run_frame("F1 full circle", 6, 1);
    check("F1 R8 saturated peak", gp, CAP);

    // half arc plus noise: R3 R6
    fn = 0; add_arc(10, 8, 5, 0, 15);
    add_pt(3, 20); add_pt(28, 2); add_pt(20, 15);
    run_frame("F2 arc noise", 5, 0);
    f2x = gx; f2y = gy; f2p = gp;

    // clipped by border, discarded candidates R3
    fn = 0; add_arc(2, 3, 6, 0, 31);
    run_frame("F3 clipped R3", 6, 0);

    // empty frame R5 defaults
    fn = 0;
    run_frame("F4 empty", 4, 0);
    check("F4 R5 empty peak zero", gp, 0);

    // small radius with duplicate offsets R2
    fn = 0; add_arc(25, 18, 3, 0, 31);
    run_frame("F5 small radius R2", 3, 0);

    // repeat F2, must match: R9
    fn = 0; add_arc(10, 8, 5, 0, 15);
    add_pt(3, 20); add_pt(28, 2); add_pt(20, 15);
    run_frame("F6 repeat", 5, 0);
    check("F6 R9 same x", gx, f2x);
    check("F6 R9 same y", gy, f2y);
    check("F6 R9 same peak", gp, f2p);

    // R12: after empty eof beat ready must drop for the scan
    send_beat(0, 0, 0, 1, 1);
    @(negedge clk);
    check("R12 ready low during scan", in_ready, 0);
    send_beat(0, 0, 0, 1, 1);
    @(negedge clk);
    while (!done) @(negedge clk);
    check("R12 empty run ctr_x", ctr_x, 0);

    finish_up();
  end

endmodule